// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Prediction

This block sits in the fetch stage of a pipelined processor and proposes the next fetch address on every cycle. It is a direct-mapped table. The low-order bits of the word address pick one entry. Each entry holds three things: the full address of a branch or jump (compared as a tag), the target that instruction last went to, and a two-bit saturating confidence counter. The fetch lookup is combinational. When the current PC hits a valid entry whose counter leans taken, the block returns the stored target. In every other case it returns PC plus one.

A resolve stage further down the pipe reports each control-flow instruction it completes. The report carries the instruction address, whether the branch was taken, its target, and whether it is an unconditional jump. The block looks that address up again in its own table to find out what it would have predicted. It then sorts the report into one of four update states:

- UPD_NONE: no report this cycle.
- UPD_TRAIN: the prediction was correct. The counter is stepped and no flush is raised.
- UPD_ALLOC: the instruction went somewhere, but the table did not predict taken. The entry is written at weak taken, and a flush to the target is requested.
- UPD_FALLTHRU: the table predicted taken, but the branch fell through. The counter is stepped down, and a flush to the address after the branch is requested.

The counter itself is a four-state machine: CTR_SNT (0), CTR_WNT (1), CTR_WT (2) and CTR_ST (3). A taken outcome moves it one state up, stopping at CTR_ST. A not-taken outcome moves it one state down, stopping at CTR_SNT. The flush request and the restart address are combinational outputs of the update port. The table is written at the next clock edge.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid. Any fetch PC gives pred_taken=0 and pred_next_pc equal to PC+1. With upd_valid low, flush_req is 0.
- R2: The entry index is fetch_pc[log2(ENTRIES)-1:0], and the full address is compared as a tag. Two addresses that share an index but differ above it never hit on each other's entry. A write for one of them evicts the other.
- R3: When the fetch PC hits a valid entry whose counter is 2 or 3 (bit 1 set), pred_taken is 1 and pred_next_pc is the stored target. Otherwise pred_taken is 0 and pred_next_pc is fetch_pc+1, wrapping modulo 2^AW.
- R4: The counter is encoded 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken. A taken outcome increments it and saturates at 3. A not-taken outcome decrements it and saturates at 0.
- R5: A taken branch or a jump that the table did not predict taken raises flush_req, and restart_pc equals upd_target. At the next edge the entry is written with upd_pc as tag, upd_target as target and counter 2. From the next cycle on, a lookup of upd_pc predicts that target.
- R6: A branch that the table predicted taken but that was not taken raises flush_req with restart_pc equal to upd_pc+1, and its counter is decremented.
- R7: A correct prediction raises no flush. A hit entry's counter is still trained. A not-taken branch that misses the table writes nothing.
- R8: A report with upd_jump=1 is treated as taken whatever upd_taken says.
- R9: When a lookup and an update address the same entry in one cycle, the lookup sees the contents from before the update. The update becomes visible in the following cycle.
- R10: With upd_valid low, flush_req stays 0 and the table is not changed, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| fetch_pc | input | AW | Current fetch word address |
| pred_taken | output | 1 | Lookup hit with a taken-leaning counter |
| pred_next_pc | output | AW | Proposed next fetch address |
| upd_valid | input | 1 | A resolved branch or jump is reported this cycle |
| upd_pc | input | AW | Address of the resolved instruction |
| upd_taken | input | 1 | Actual branch outcome |
| upd_jump | input | 1 | Resolved instruction is an unconditional jump |
| upd_target | input | AW | Actual target of the instruction |
| flush_req | output | 1 | Misprediction: the wrongly fetched instructions must be dropped |
| restart_pc | output | AW | Address to fetch from after a flush |

## Verification
Two events can meet in one cycle: a fetch lookup and a resolve update that land on the same table entry. The bench provokes this from its vector table. In those vectors the fetch address equals the update address, and the update allocates, retrains or replaces that entry. The lookup result in that cycle must match the old contents. The bench then checks the next vector, which must show the new contents. This covers the first allocation, the change of direction when a counter crosses between 1 and 2, and an alias at the same index evicting another branch.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // two-bit confidence state, value order matters: bit 1 is the direction
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    // classification of one resolve-stage report
    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_TRAIN    = 2'd1,
        UPD_ALLOC    = 2'd2,
        UPD_FALLTHRU = 2'd3
    } upd_kind_e;

    // saturating step of the confidence state machine
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_leans_taken(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    // fetch-side read port
    input  logic [IW-1:0] fa_idx,
    output logic          fa_valid,
    output logic [AW-1:0] fa_tag,
    output logic [AW-1:0] fa_target,
    output ctr_e          fa_ctr,
    // resolve-side read port
    input  logic [IW-1:0] rb_idx,
    output logic          rb_valid,
    output logic [AW-1:0] rb_tag,
    output logic [AW-1:0] rb_target,
    output ctr_e          rb_ctr,
    // single write port
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_tag,
    input  logic [AW-1:0] wr_target,
    input  ctr_e          wr_ctr
);

    logic [ENTRIES-1:0] valid_q;
    logic [AW-1:0]      tag_q    [ENTRIES];
    logic [AW-1:0]      target_q [ENTRIES];
    ctr_e               ctr_q    [ENTRIES];

    // valid bits are the only reset state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // payload arrays, written without reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
            ctr_q[wr_idx]    <= wr_ctr;
        end
    end

    // reads see registered contents: a same-cycle write shows up next cycle
    always_comb begin
        fa_valid  = valid_q[fa_idx];
        fa_tag    = tag_q[fa_idx];
        fa_target = target_q[fa_idx];
        fa_ctr    = ctr_q[fa_idx];
        rb_valid  = valid_q[rb_idx];
        rb_tag    = tag_q[rb_idx];
        rb_target = target_q[rb_idx];
        rb_ctr    = ctr_q[rb_idx];
    end

endmodule

// File: rtl/btb_fetch_sel.sv
module btb_fetch_sel
    import btb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] fetch_pc,
    input  logic          ent_valid,
    input  logic [AW-1:0] ent_tag,
    input  logic [AW-1:0] ent_target,
    input  ctr_e          ent_ctr,
    output logic          take,
    output logic [AW-1:0] next_pc
);

    logic tag_hit;

    always_comb begin
        tag_hit = ent_valid && (ent_tag == fetch_pc);
        take    = tag_hit && ctr_leans_taken(ent_ctr);
        next_pc = take ? ent_target : fetch_pc + AW'(1);
    end

endmodule

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl
    import btb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_pc,
    input  logic          upd_taken,
    input  logic          upd_jump,
    input  logic [AW-1:0] upd_target,
    input  logic          ent_valid,
    input  logic [AW-1:0] ent_tag,
    input  logic [AW-1:0] ent_target,
    input  ctr_e          ent_ctr,
    output upd_kind_e     kind,
    output logic          wr_en,
    output logic [AW-1:0] wr_target,
    output ctr_e          wr_ctr,
    output logic          flush,
    output logic [AW-1:0] restart
);

    logic went;       // jump or taken branch
    logic hit;
    logic was_taken;  // what the table predicts for upd_pc right now

    // classification process
    always_comb begin
        went      = upd_taken || upd_jump;
        hit       = ent_valid && (ent_tag == upd_pc);
        was_taken = hit && ctr_leans_taken(ent_ctr);
        if (!upd_valid) begin
            kind = UPD_NONE;
        end else if (went && !was_taken) begin
            kind = UPD_ALLOC;
        end else if (!went && was_taken) begin
            kind = UPD_FALLTHRU;
        end else begin
            kind = UPD_TRAIN;
        end
    end

    // output process per classified state
    always_comb begin
        wr_en     = 1'b0;
        wr_target = went ? upd_target : ent_target;
        wr_ctr    = ent_ctr;
        flush     = 1'b0;
        restart   = upd_pc + AW'(1);
        unique case (kind)
            UPD_NONE: begin
                wr_en = 1'b0;
            end
            UPD_ALLOC: begin
                wr_en   = 1'b1;
                wr_ctr  = CTR_WT;
                flush   = 1'b1;
                restart = upd_target;
            end
            UPD_FALLTHRU: begin
                wr_en  = 1'b1;
                wr_ctr = ctr_step(ent_ctr, 1'b0);
                flush  = 1'b1;
            end
            UPD_TRAIN: begin
                wr_en  = hit;
                wr_ctr = ctr_step(ent_ctr, went);
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] fetch_pc,
    output logic          pred_taken,
    output logic [AW-1:0] pred_next_pc,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_pc,
    input  logic          upd_taken,
    input  logic          upd_jump,
    input  logic [AW-1:0] upd_target,
    output logic          flush_req,
    output logic [AW-1:0] restart_pc
);

    logic          fa_valid, rb_valid;
    logic [AW-1:0] fa_tag, fa_target, rb_tag, rb_target;
    ctr_e          fa_ctr, rb_ctr;
    upd_kind_e     upd_kind;
    logic          wr_en;
    logic [AW-1:0] wr_target;
    ctr_e          wr_ctr;

    btb_store #(.ENTRIES(ENTRIES), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fa_idx    (fetch_pc[IW-1:0]),
        .fa_valid  (fa_valid),
        .fa_tag    (fa_tag),
        .fa_target (fa_target),
        .fa_ctr    (fa_ctr),
        .rb_idx    (upd_pc[IW-1:0]),
        .rb_valid  (rb_valid),
        .rb_tag    (rb_tag),
        .rb_target (rb_target),
        .rb_ctr    (rb_ctr),
        .wr_en     (wr_en),
        .wr_idx    (upd_pc[IW-1:0]),
        .wr_tag    (upd_pc),
        .wr_target (wr_target),
        .wr_ctr    (wr_ctr)
    );

    btb_fetch_sel #(.AW(AW)) u_fetch (
        .fetch_pc   (fetch_pc),
        .ent_valid  (fa_valid),
        .ent_tag    (fa_tag),
        .ent_target (fa_target),
        .ent_ctr    (fa_ctr),
        .take       (pred_taken),
        .next_pc    (pred_next_pc)
    );

    btb_update_ctrl #(.AW(AW)) u_upd (
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_jump   (upd_jump),
        .upd_target (upd_target),
        .ent_valid  (rb_valid),
        .ent_tag    (rb_tag),
        .ent_target (rb_target),
        .ent_ctr    (rb_ctr),
        .kind       (upd_kind),
        .wr_en      (wr_en),
        .wr_target  (wr_target),
        .wr_ctr     (wr_ctr),
        .flush      (flush_req),
        .restart    (restart_pc)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_pc,
    input logic          pred_taken,
    input logic [AW-1:0] pred_next_pc,
    input logic          upd_valid,
    input logic [AW-1:0] upd_pc,
    input logic          upd_taken,
    input logic          upd_jump,
    input logic [AW-1:0] upd_target,
    input logic          flush_req,
    input logic [AW-1:0] restart_pc
);

    p_seq_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + AW'(1));

    p_alloc_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && (upd_taken || upd_jump)) |-> restart_pc == upd_target);

    p_alloc_learned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && flush_req && (upd_taken || upd_jump)) |=>
        ((fetch_pc != $past(upd_pc)) ||
         (pred_taken && pred_next_pc == $past(upd_target))));

    p_fallthru_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !upd_taken && !upd_jump) |-> restart_pc == upd_pc + AW'(1));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !flush_req);

endmodule

bind btb_predictor btb_predictor_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_jump     (upd_jump),
    .upd_target   (upd_target),
    .flush_req    (flush_req),
    .restart_pc   (restart_pc)
);

// File: tb/btb_predictor_test.sv
`timescale 1ns/1ps
module btb_predictor_test;

    localparam int AW = 32;

    typedef struct packed {
        logic          uv;
        logic [AW-1:0] upc;
        logic          tk;
        logic          jp;
        logic [AW-1:0] tgt;
        logic [AW-1:0] fpc;
        logic          e_flush;
        logic [AW-1:0] e_rst;
        logic          e_ptk;
        logic [AW-1:0] e_npc;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 20;
    // each row: update inputs, fetch pc, expected flush/restart, expected lookup
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h40, 1'b1, 1'b0, 32'h100, 32'h40, 1'b1, 32'h100, 1'b0, 32'h41, 4'd9}, // R9 R5 first alloc, lookup old
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'h40, 1'b0, 32'h0,   1'b1, 32'h100, 4'd5}, // R5 learned, R3
        '{1'b1, 32'h40, 1'b1, 1'b0, 32'h100, 32'h40, 1'b0, 32'h0,   1'b1, 32'h100, 4'd7}, // R7 correct, 2->3
        '{1'b1, 32'h40, 1'b1, 1'b0, 32'h100, 32'h50, 1'b0, 32'h0,   1'b0, 32'h51, 4'd2}, // R2 alias miss, R4 sat 3
        '{1'b1, 32'h40, 1'b0, 1'b0, 32'h0,   32'h40, 1'b1, 32'h41,  1'b1, 32'h100, 4'd6}, // R6 3->2
        '{1'b1, 32'h40, 1'b0, 1'b0, 32'h0,   32'h40, 1'b1, 32'h41,  1'b1, 32'h100, 4'd4}, // R4 2->1 still flush
        '{1'b1, 32'h40, 1'b0, 1'b0, 32'h0,   32'h40, 1'b0, 32'h0,   1'b0, 32'h41, 4'd4}, // R4 1->0, R9 lookup sees 1
        '{1'b1, 32'h40, 1'b0, 1'b0, 32'h0,   32'h40, 1'b0, 32'h0,   1'b0, 32'h41, 4'd4}, // R4 sat 0
        '{1'b1, 32'h40, 1'b1, 1'b0, 32'h100, 32'h40, 1'b1, 32'h100, 1'b0, 32'h41, 4'd5}, // R5 0 -> 2
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'h40, 1'b0, 32'h0,   1'b1, 32'h100, 4'd5}, // R5
        '{1'b1, 32'h23, 1'b0, 1'b1, 32'h200, 32'h23, 1'b1, 32'h200, 1'b0, 32'h24, 4'd8}, // R8 jump alloc
        '{1'b1, 32'h23, 1'b0, 1'b1, 32'h200, 32'h23, 1'b0, 32'h0,   1'b1, 32'h200, 4'd8}, // R8 jump correct
        '{1'b1, 32'h53, 1'b0, 1'b0, 32'h0,   32'h53, 1'b0, 32'h0,   1'b0, 32'h54, 4'd7}, // R7 nt miss, no write
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'h23, 1'b0, 32'h0,   1'b1, 32'h200, 4'd7}, // R7 entry 3 kept
        '{1'b1, 32'h33, 1'b1, 1'b0, 32'h300, 32'h23, 1'b1, 32'h300, 1'b1, 32'h200, 4'd2}, // R2 alias replace, old seen
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'h23, 1'b0, 32'h0,   1'b0, 32'h24, 4'd2}, // R2 evicted
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'h33, 1'b0, 32'h0,   1'b1, 32'h300, 4'd2}, // R2 new owner
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'hFFFFFFFF, 1'b0, 32'h0, 1'b0, 32'h0, 4'd3}, // R3 wrap
        '{1'b0, 32'h33, 1'b0, 1'b0, 32'h0,   32'h33, 1'b0, 32'h0,   1'b1, 32'h300, 4'd10}, // R10 ignored report
        '{1'b0, 32'h0,  1'b0, 1'b0, 32'h0,   32'h33, 1'b0, 32'h0,   1'b1, 32'h300, 4'd10}  // R10 entry unchanged
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_taken;
    logic [AW-1:0] pred_next_pc;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic          upd_jump = 1'b0;
    logic [AW-1:0] upd_target = '0;
    logic          flush_req;
    logic [AW-1:0] restart_pc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    btb_predictor #(.ENTRIES(16), .AW(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_taken   (pred_taken),
        .pred_next_pc (pred_next_pc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_jump     (upd_jump),
        .upd_target   (upd_target),
        .flush_req    (flush_req),
        .restart_pc   (restart_pc)
    );

    task automatic check(input string what, input int req,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic uv, input logic [AW-1:0] upc, input logic tk,
                         input logic jp, input logic [AW-1:0] tgt, input logic [AW-1:0] fpc);
        @(negedge clk);
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = tk;
        upd_jump   = jp;
        upd_target = tgt;
        fetch_pc   = fpc;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset
        drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h40);
        check("reset taken", 1, AW'(pred_taken), '0);
        check("reset next pc", 1, pred_next_pc, 32'h41);
        check("reset flush", 1, AW'(flush_req), '0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].uv, VEC[i].upc, VEC[i].tk, VEC[i].jp, VEC[i].tgt, VEC[i].fpc);
            check($sformatf("vec %0d flush", i), int'(VEC[i].req), AW'(flush_req), AW'(VEC[i].e_flush));
            if (VEC[i].e_flush)
                check($sformatf("vec %0d restart", i), int'(VEC[i].req), restart_pc, VEC[i].e_rst);
            check($sformatf("vec %0d taken", i), int'(VEC[i].req), AW'(pred_taken), AW'(VEC[i].e_ptk));
            check($sformatf("vec %0d next pc", i), int'(VEC[i].req), pred_next_pc, VEC[i].e_npc);
        end

        // R6 fall-through restart must not wrap into the target: entry 0x33 at 2
        drive(1'b1, 32'h33, 1'b0, 1'b0, 32'h0, 32'h33);
        check("fallthru flush", 6, AW'(flush_req), 32'h1);
        check("fallthru restart", 6, restart_pc, 32'h34);
        // R4: 2 -> 1 so lookup now falls through
        drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h33);
        check("after decrement", 4, AW'(pred_taken), '0);

        // R1: reset mid-run clears every entry
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h40);
        check("post reset 0x40", 1, pred_next_pc, 32'h41);
        drive(1'b0, '0, 1'b0, 1'b0, '0, 32'h23);
        check("post reset 0x23", 1, AW'(pred_taken), '0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule